// File: doc/BRIEF.md
# Unmaskable Exception Sequencer

This block sits next to a small 16-bit processor core and decides, at each instruction boundary, whether one of three exceptions that software cannot mask must be taken: a divide overflow, an asynchronous nonmaskable interrupt (NMI) pin, or the single-step trace trap. When it takes an exception, it gives the core a one-cycle take pulse and an 8-bit vector type. It also gives the commands to clear the interrupt-enable flag and, for a trace trap, the trace flag. The core saves its flags before it acts on those commands.

An instruction boundary is the cycle after a retire strobe. Requests that arrive between boundaries are held. If several are waiting, a fixed order picks one, and the others stay pending. The NMI pin passes through a synchronizer. It arms only on a rising edge, cannot be masked and has no in-service state, so a second edge during an NMI handler is taken again.

Top module: `exc_req_seq`

## Requirements
- R1: After a synchronous reset, take_o, clr_if_o and clr_tf_o are low until an exception is taken.
- R2: The vector type is 8'h00 for divide overflow, 8'h01 for the trace trap and 8'h02 for NMI.
- R3: A divide-overflow strobe is taken with vector 8'h00 in the cycle after the next retire strobe. This includes a retire strobe in the same cycle as the divide-overflow strobe.
- R4: Only a low-to-high change of the NMI pin creates a request. A pin held high creates exactly one request.
- R5: An NMI pin that is already high during reset and at reset release creates no request.
- R6: The interrupt-enable input if_i has no effect on whether NMI is taken.
- R7: NMI has no in-service state. Two separate rising edges give two NMI takes, even while the first is being serviced.
- R8: With tf_i high, every retired instruction causes a trace take, unless the instruction was flagged as a prefix, a segment-register write or WAIT.
- R9: clr_if_o is high in every take cycle. clr_tf_o is high only in a take cycle with vector 8'h01.
- R10: Requests at the same boundary are taken in this order: divide first, then NMI, then trace. Requests that are not taken stay pending, but a pending trace request is discarded when tf_i is low.
- R11: take_o is a single-cycle pulse, given only in a boundary cycle. Each accepted request gives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_ovf_i | input | 1 | Divide quotient overflow strobe |
| retire_i | input | 1 | Instruction retire strobe |
| ret_prefix_i | input | 1 | Retired instruction was a prefix |
| ret_segwr_i | input | 1 | Retired instruction wrote a segment register |
| ret_wait_i | input | 1 | Retired instruction was WAIT |
| tf_i | input | 1 | Current trace flag |
| if_i | input | 1 | Current interrupt-enable flag |
| nmi_pin_i | input | 1 | Raw asynchronous NMI pin |
| take_o | output | 1 | Exception taken this cycle |
| vec_type_o | output | 8 | Vector type of the taken exception |
| clr_if_o | output | 1 | Command to clear the interrupt-enable flag |
| clr_tf_o | output | 1 | Command to clear the trace flag |

## Verification
The pin patterns are a level held through reset, a level held for many boundaries, and two short pulses with if_i low. Together they tell edge arming apart from level sensing, separate reset initialisation from edge detection, and show that there is no in-service blocking. Trace is tried after plain, prefix, segment-write and WAIT retires, which shows that each exemption acts on its own. A divide strobe, a pending NMI and a trace request are made to meet at one boundary, which exposes the priority order and whether losing requests are kept. A run with tf_i dropped shows that stale trace requests are discarded.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;

    localparam vec_t VEC_DIV   = 8'h00;
    localparam vec_t VEC_TRACE = 8'h01;
    localparam vec_t VEC_NMI   = 8'h02;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DIV   = 2'd1,
        SRC_NMI   = 2'd2,
        SRC_TRACE = 2'd3
    } src_e;

    typedef struct packed {
        logic div;
        logic nmi;
        logic trace;
    } req_t;

    // fixed order: divide, then NMI, then trace
    function automatic src_e pick_src(input req_t r);
        if (r.div)        return SRC_DIV;
        else if (r.nmi)   return SRC_NMI;
        else if (r.trace) return SRC_TRACE;
        else              return SRC_NONE;
    endfunction

    function automatic vec_t src_vec(input src_e s);
        case (s)
            SRC_NMI:   return VEC_NMI;
            SRC_TRACE: return VEC_TRACE;
            default:   return VEC_DIV;
        endcase
    endfunction

endpackage

// File: rtl/exc_nmi_detect.sv
module exc_nmi_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic ack_i,
    output logic pend_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rise;
    logic                   pend_q;

    // reset to "high" so a pin already high at release is not an edge
    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b1;
                    else     sync_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b1;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;

    // a new edge in the accept cycle keeps the request armed
    always_ff @(posedge clk) begin
        if (rst)        pend_q <= 1'b0;
        else if (rise)  pend_q <= 1'b1;
        else if (ack_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    // R4
    nmi_arm_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(rise));

    // R11
    nmi_ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !rise) |=> !pend_q);

endmodule

// File: rtl/exc_pend_latch.sv
module exc_pend_latch (
    input  logic clk,
    input  logic rst,
    input  logic div_ovf_i,
    input  logic retire_i,
    input  logic ret_prefix_i,
    input  logic ret_segwr_i,
    input  logic ret_wait_i,
    input  logic tf_i,
    input  logic div_ack_i,
    input  logic trace_ack_i,
    output logic div_pend_o,
    output logic trace_pend_o,
    output logic bnd_o
);
    logic div_q, trace_q, bnd_q;
    logic exempt, trace_set;

    assign exempt    = ret_prefix_i | ret_segwr_i | ret_wait_i;
    assign trace_set = retire_i & tf_i & ~exempt;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= 1'b0;
            trace_q <= 1'b0;
            bnd_q   <= 1'b0;
        end else begin
            bnd_q <= retire_i;
            if (div_ovf_i)      div_q <= 1'b1;
            else if (div_ack_i) div_q <= 1'b0;
            if (trace_set)                     trace_q <= 1'b1;
            else if (trace_ack_i || !tf_i)     trace_q <= 1'b0;
        end
    end

    assign div_pend_o   = div_q;
    assign trace_pend_o = trace_q;
    assign bnd_o        = bnd_q;

    // R8
    trace_exempt_chk: assert property (@(posedge clk) disable iff (rst)
        (retire_i && exempt && !trace_q) |=> !trace_q);

    // R10
    trace_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !tf_i |=> !trace_q);

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
    import exc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req_i,
    input  logic bnd_i,
    output logic take_o,
    output req_t grant_o,
    output vec_t vec_o
);
    src_e sel;

    always_comb begin
        sel     = bnd_i ? pick_src(req_i) : SRC_NONE;
        grant_o = '0;
        case (sel)
            SRC_DIV:   grant_o.div   = 1'b1;
            SRC_NMI:   grant_o.nmi   = 1'b1;
            SRC_TRACE: grant_o.trace = 1'b1;
            default:   grant_o       = '0;
        endcase
        take_o = (sel != SRC_NONE);
        vec_o  = take_o ? src_vec(sel) : '0;
    end

    // R11
    grant_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o));

    // R10
    nmi_below_div_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o.nmi |-> !req_i.div);

    // R10
    trace_last_chk: assert property (@(posedge clk) disable iff (rst)
        grant_o.trace |-> (!req_i.div && !req_i.nmi));

endmodule

// File: rtl/exc_req_seq.sv
module exc_req_seq
    import exc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       div_ovf_i,
    input  logic       retire_i,
    input  logic       ret_prefix_i,
    input  logic       ret_segwr_i,
    input  logic       ret_wait_i,
    input  logic       tf_i,
    input  logic       if_i,
    input  logic       nmi_pin_i,
    output logic       take_o,
    output logic [7:0] vec_type_o,
    output logic       clr_if_o,
    output logic       clr_tf_o
);
    req_t req, grant;
    logic bnd;
    logic take;
    vec_t vec;

    exc_nmi_detect #(.SYNC_STAGES(SYNC_STAGES)) u_nmi (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (nmi_pin_i),
        .ack_i  (grant.nmi),
        .pend_o (req.nmi)
    );

    exc_pend_latch u_pend (
        .clk          (clk),
        .rst          (rst),
        .div_ovf_i    (div_ovf_i),
        .retire_i     (retire_i),
        .ret_prefix_i (ret_prefix_i),
        .ret_segwr_i  (ret_segwr_i),
        .ret_wait_i   (ret_wait_i),
        .tf_i         (tf_i),
        .div_ack_i    (grant.div),
        .trace_ack_i  (grant.trace),
        .div_pend_o   (req.div),
        .trace_pend_o (req.trace),
        .bnd_o        (bnd)
    );

    exc_prio_pick u_pick (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req),
        .bnd_i   (bnd),
        .take_o  (take),
        .grant_o (grant),
        .vec_o   (vec)
    );

    assign take_o     = take;
    assign vec_type_o = vec;
    assign clr_if_o   = take;
    assign clr_tf_o   = grant.trace;

    // R11
    take_on_bnd_chk: assert property (@(posedge clk) disable iff (rst)
        take_o |-> bnd);

    // R9
    clr_tf_vec_chk: assert property (@(posedge clk) disable iff (rst)
        clr_tf_o |-> (take_o && vec_type_o == VEC_TRACE));

    // R6
    nmi_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && req.nmi && !req.div && !if_i) |-> (take_o && vec_type_o == VEC_NMI));

    // R3
    div_first_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd && req.div) |-> (take_o && vec_type_o == VEC_DIV));

endmodule

// File: tb/exc_req_seq_test.sv
`timescale 1ns/1ps
module exc_req_seq_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic div_ovf = 0, retire = 0, pfx = 0, segwr = 0, wt = 0;
    logic tf = 0, ie = 1, nmi = 0;
    logic take, clr_if, clr_tf;
    logic [7:0] vec;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;

    // reference model state
    bit m_s0 = 1, m_s1 = 1, m_prev = 1;
    bit m_bnd = 0, m_div = 0, m_nmi = 0, m_tr = 0;
    byte unsigned taken_q[$];

    always #2 clk = ~clk;

    exc_req_seq uut (
        .clk(clk), .rst(rst), .div_ovf_i(div_ovf), .retire_i(retire),
        .ret_prefix_i(pfx), .ret_segwr_i(segwr), .ret_wait_i(wt),
        .tf_i(tf), .if_i(ie), .nmi_pin_i(nmi),
        .take_o(take), .vec_type_o(vec), .clr_if_o(clr_if), .clr_tf_o(clr_tf)
    );

    function automatic bit e_take();
        return m_bnd && (m_div || m_nmi || m_tr);
    endfunction
    function automatic byte unsigned e_vec();
        if (!e_take()) return 8'h00;
        if (m_div) return 8'h00;
        if (m_nmi) return 8'h02;
        return 8'h01;
    endfunction
    function automatic bit e_tf();
        return e_take() && !m_div && !m_nmi && m_tr;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // behavioural model update
    always @(posedge clk) begin
        bit tk, gd, gn, gt, edge_seen;
        cyc++;
        if (rst) begin
            m_s0 = 1; m_s1 = 1; m_prev = 1;
            m_bnd = 0; m_div = 0; m_nmi = 0; m_tr = 0;
        end else begin
            tk = e_take();
            gd = tk && m_div;
            gn = tk && !m_div && m_nmi;
            gt = e_tf();
            edge_seen = m_s1 && !m_prev;
            m_div = div_ovf || (m_div && !gd);
            m_nmi = edge_seen || (m_nmi && !gn);
            m_tr  = (retire && tf && !(pfx || segwr || wt)) || (m_tr && !gt && tf);
            m_bnd = retire;
            m_prev = m_s1; m_s1 = m_s0; m_s0 = nmi;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R11 take", int'(take), int'(e_take()));
            chk("R2 vector", int'(vec), int'(e_vec()));
            chk("R9 clr_if", int'(clr_if), int'(e_take()));
            chk("R9 clr_tf", int'(clr_tf), int'(e_tf()));
            if (take) taken_q.push_back(vec);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic retire_one(input bit p, input bit s, input bit w);
        retire = 1; pfx = p; segwr = s; wt = w;
        step(1);
        retire = 0; pfx = 0; segwr = 0; wt = 0;
    endtask

    task automatic count_vec(input byte unsigned v, output int c);
        c = 0;
        foreach (taken_q[i]) if (taken_q[i] == v) c++;
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c;
        // R5: pin high throughout reset
        nmi = 1;
        step(5);
        rst = 0;
        step(1);
        @(negedge clk);
        // R1
        chk("R1 reset take", int'(take), 0);
        chk("R1 reset clr_if", int'(clr_if), 0);
        chk("R1 reset clr_tf", int'(clr_tf), 0);
        @(posedge clk); #1;
        for (int i = 0; i < 10; i++) retire_one(0, 0, 0);
        step(3);
        count_vec(8'h02, c);
        chk("R5 nmi high at reset", c, 0);
        nmi = 0;
        step(6);

        // R4: held high gives a single request
        taken_q.delete();
        nmi = 1;
        retire = 1;
        step(20);
        retire = 0;
        step(2);
        count_vec(8'h02, c);
        chk("R4 held-high single nmi", c, 1);
        nmi = 0;
        step(6);

        // R7 + R6: two edges with IF low, continuous boundaries
        taken_q.delete();
        ie = 0;
        retire = 1;
        nmi = 1; step(3);
        nmi = 0; step(3);
        nmi = 1; step(3);
        nmi = 0; step(8);
        retire = 0;
        step(2);
        count_vec(8'h02, c);
        chk("R7 two nmi edges", c, 2);
        chk("R6 nmi with if low", taken_q.size(), 2);
        ie = 1;

        // R3: divide strobe with its retire
        taken_q.delete();
        div_ovf = 1; retire = 1;
        step(1);
        div_ovf = 0; retire = 0;
        step(5);
        chk("R3 divide take count", taken_q.size(), 1);
        if (taken_q.size() == 1) chk("R3 divide vector", int'(taken_q[0]), 0);

        // R8: trace after plain and exempt retires
        tf = 1;
        taken_q.delete();
        retire_one(0, 0, 0); step(3);
        count_vec(8'h01, c);
        chk("R8 trace after plain retire", c, 1);
        taken_q.delete();
        retire_one(1, 0, 0); step(3);
        chk("R8 no trace after prefix", taken_q.size(), 0);
        retire_one(0, 1, 0); step(3);
        chk("R8 no trace after segment write", taken_q.size(), 0);
        retire_one(0, 0, 1); step(3);
        chk("R8 no trace after wait", taken_q.size(), 0);

        // R10: divide, NMI, trace meeting at one boundary
        taken_q.delete();
        nmi = 1; step(6);
        div_ovf = 1; retire = 1;
        step(1);
        div_ovf = 0; retire = 0;
        step(2);
        retire_one(0, 0, 0); step(2);
        retire_one(0, 0, 0); step(2);
        chk("R10 order count", taken_q.size(), 3);
        if (taken_q.size() == 3) begin
            chk("R10 first divide", int'(taken_q[0]), 8'h00);
            chk("R10 second nmi", int'(taken_q[1]), 8'h02);
            chk("R10 third trace", int'(taken_q[2]), 8'h01);
        end
        nmi = 0; step(6);

        // R10: pending trace dropped when tf falls
        taken_q.delete();
        nmi = 1; step(6);
        retire = 1;
        step(1);
        retire = 0; tf = 0;
        step(3);
        retire_one(0, 0, 0); step(3);
        chk("R10 trace dropped", taken_q.size(), 1);
        if (taken_q.size() == 1) chk("R10 only nmi taken", int'(taken_q[0]), 8'h02);
        nmi = 0; step(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule